// File: doc/BRIEF.md
# Expansion Bus Slave Request Screen

This block sits behind the AHB slave port of an external expansion bus controller. It looks at every address phase aimed at the controller and decides whether the controller can carry that request out against the chip select being addressed. The decision uses the transfer type, burst kind, size, direction and low address bits, together with the addressed chip select's configuration: its data width, its device family, and a flag that allows byte reads on 16-bit parts.

An accepted request becomes a normalised command: direction, size, beat count, a wrap flag and the start address. The command is handed downstream over a valid/ready pair, and the AHB data phase is stretched until downstream takes it. A refused request is not split or retried. It receives the usual two-cycle AHB ERROR reply.

For undefined-length incrementing reads, the controller prefetches up to the end of the current 8-word line. The block reports that word count in the command. Idle, busy and sequential beats get an immediate OKAY and produce no command.

Top module: `exp_cmd_filter`

## Requirements
- R1: While reset is asserted and directly after it, hreadyout is 1, hresp is 0 (OKAY) and cmd_valid is 0.
- R2: An address phase is sampled only when hsel=1 and hreadyout=1. A sampled htrans of IDLE (2'b00), BUSY (2'b01) or SEQ (2'b11), or hsel=0, gives an OKAY reply with no wait state and no command.
- R3: For a SINGLE (hburst=3'b000) NONSEQ (2'b10) request:
  - hsize=0 (byte) has no alignment rule.
  - hsize=1 (halfword) needs haddr[0]=0.
  - hsize=2 (word) needs haddr[1:0]=0.
  - hsize above 2 is refused.
- R4: A single byte read is refused when cfg_width=1 (16-bit) and cfg_byte_rd=0. With cfg_byte_rd=1, or with an 8-bit (0) or 32-bit (2) width, it is accepted.
- R5: For cfg_kind=1 (synchronous flash), a single byte write is always refused. A single halfword write is refused when cfg_width=1.
- R6: INCR4 (3'b011) and INCR8 (3'b101) are accepted only as word transfers with haddr[4:0] <= 5'b10000. Writes of these bursts are accepted only when cfg_kind=2 (ZBT SRAM) and cfg_width=2.
- R7: WRAP8 (3'b100) is accepted only as a word read with haddr[4:0]=0. The following are always refused:
  - WRAP8 writes
  - WRAP4 (3'b010)
  - WRAP16 (3'b110)
  - INCR16 (3'b111)
- R8: Undefined-length INCR (3'b001) is accepted only as an aligned word transfer to cfg_kind=2 with cfg_width=2. For a read, cmd_beats = 8 - haddr[4:2]. For a write, cmd_beats = 0, meaning open-ended.
- R9: When cfg_kind is 3 (HPI 8-bit) or 4 (HPI 16-bit), only a SINGLE halfword with haddr[0]=0 is accepted, in either direction.
- R10: A refused NONSEQ gives two reply cycles. The first has hreadyout=0 and hresp=1. The second has hreadyout=1 and hresp=1. The cycle after that is OKAY unless a new request was sampled.
- R11: After an accepted NONSEQ, cmd_valid is 1 from the next cycle. It holds, with all command fields stable, until cmd_ready=1. hreadyout equals cmd_ready in every such cycle.
- R12: Command fields:
  - cmd_write, cmd_size (haddr-independent copy of hsize[1:0]) and cmd_addr copy the request.
  - cmd_wrap=1 only for WRAP8.
  - cmd_beats is 1 for SINGLE, 4 for INCR4 and 8 for INCR8 or WRAP8.
- R13: The reserved configuration codes cfg_width=3 and cfg_kind of 5 to 7 make every NONSEQ request refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type |
| hburst | input | 3 | Burst kind |
| hsize | input | 3 | Transfer size |
| hwrite | input | 1 | 1 = write |
| haddr | input | AW | Address |
| cfg_width | input | 2 | Addressed chip select width: 0=8, 1=16, 2=32, 3 reserved |
| cfg_kind | input | 3 | Device family: 0 async, 1 sync flash, 2 ZBT SRAM, 3 HPI-8, 4 HPI-16 |
| cfg_byte_rd | input | 1 | Permit byte reads on a 16-bit part |
| hreadyout | output | 1 | Data phase done |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| cmd_valid | output | 1 | Command offered downstream |
| cmd_ready | input | 1 | Downstream takes command |
| cmd_write | output | 1 | Command direction |
| cmd_size | output | 2 | Command beat size |
| cmd_wrap | output | 1 | Wrapping burst |
| cmd_beats | output | BW | Beat count, 0 = open-ended |
| cmd_addr | output | AW | Start address |

## Verification
The interesting overlap is a handoff finishing in the same cycle as the next request is sampled. Because hreadyout follows cmd_ready during the wait, the next address phase is sampled in the very cycle the pending command is taken. The same happens in the second ERROR cycle.

The bench provokes both overlaps. It presents a new NONSEQ while cmd_ready rises, and it presents one during the closing ERROR beat. The cycle-level reference model then judges the result. It must show the new command or the new ERROR on the following cycle, with no idle cycle inserted and no request dropped.

// File: rtl/exp_cmd_pkg.sv
package exp_cmd_pkg;
  typedef enum logic [1:0] {TR_IDLE = 2'b00, TR_BUSY = 2'b01, TR_NSEQ = 2'b10, TR_SEQ = 2'b11} trans_e;
  typedef enum logic [2:0] {
    BU_SINGLE = 3'b000, BU_INCR = 3'b001, BU_WRAP4 = 3'b010, BU_INCR4 = 3'b011,
    BU_WRAP8 = 3'b100, BU_INCR8 = 3'b101, BU_WRAP16 = 3'b110, BU_INCR16 = 3'b111
  } burst_e;
  typedef enum logic [1:0] {DW_8 = 2'd0, DW_16 = 2'd1, DW_32 = 2'd2, DW_RSV = 2'd3} dev_width_e;
  typedef enum logic [2:0] {
    DK_ASYNC = 3'd0, DK_SFLASH = 3'd1, DK_ZBT = 3'd2, DK_HPI8 = 3'd3, DK_HPI16 = 3'd4
  } dev_kind_e;
  typedef enum logic [1:0] {RS_OPEN, RS_HOLD, RS_ERR_A, RS_ERR_B} rsp_state_e;
endpackage

// File: rtl/exp_cmd_span.sv
module exp_cmd_span #(
  parameter int LINE_WORDS = 8,
  localparam int IW = $clog2(LINE_WORDS),
  localparam int BW = IW + 1
) (
  input  logic [IW+1:0] addr_lo,
  output logic [BW-1:0] words_left
);
  logic [BW-1:0] line_len;
  logic [BW-1:0] word_idx;

  always_comb begin
    line_len   = BW'(LINE_WORDS);
    word_idx   = {1'b0, addr_lo[IW+1:2]};
    words_left = line_len - word_idx;
  end
endmodule

// File: rtl/exp_cmd_rules.sv
module exp_cmd_rules
  import exp_cmd_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int IW = $clog2(LINE_WORDS),
  localparam int BW = IW + 1,
  localparam int LW = IW + 2,
  localparam int START_MAX = LINE_WORDS * 2
) (
  input  logic [2:0]    burst,
  input  logic [2:0]    size,
  input  logic          write,
  input  logic [LW-1:0] addr_lo,
  input  logic [1:0]    width,
  input  logic [2:0]    kind,
  input  logic          byte_rd,
  output logic          legal,
  output logic          wrap,
  output logic [BW-1:0] beats
);
  logic [BW-1:0] span_words;
  logic is_hpi, is_zbt32, is_sync, cfg_bad, half_ok, word_ok, word_sz, start_ok;
  logic base_ok;

  exp_cmd_span #(.LINE_WORDS(LINE_WORDS)) u_span (
    .addr_lo   (addr_lo),
    .words_left(span_words)
  );

  always_comb begin
    is_hpi   = (kind == DK_HPI8) || (kind == DK_HPI16);
    is_zbt32 = (kind == DK_ZBT) && (width == DW_32);
    is_sync  = (kind == DK_SFLASH);
    cfg_bad  = (width == DW_RSV) || (kind > DK_HPI16);
    half_ok  = ~addr_lo[0];
    word_ok  = (addr_lo[1:0] == 2'b00);
    word_sz  = (size == 3'd2);
    start_ok = (LW'(START_MAX) >= addr_lo);
  end

  always_comb begin
    base_ok = 1'b0;
    wrap    = 1'b0;
    beats   = BW'(1);
    unique case (burst_e'(burst))
      BU_SINGLE: begin
        unique case (size)
          3'd0:    base_ok = write ? ~is_sync : ((width != DW_16) || byte_rd);
          3'd1:    base_ok = half_ok && !(write && is_sync && (width == DW_16));
          3'd2:    base_ok = word_ok;
          default: base_ok = 1'b0;
        endcase
      end
      BU_INCR4, BU_INCR8: begin
        beats   = (burst == BU_INCR4) ? BW'(4) : BW'(8);
        base_ok = word_sz && word_ok && start_ok && (!write || is_zbt32);
      end
      BU_WRAP8: begin
        beats   = BW'(8);
        wrap    = 1'b1;
        base_ok = !write && word_sz && (addr_lo == '0);
      end
      BU_INCR: begin
        beats   = write ? '0 : span_words;
        base_ok = word_sz && word_ok && is_zbt32;
      end
      default: base_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (cfg_bad)
      legal = 1'b0;
    else if (is_hpi)
      legal = (burst == BU_SINGLE) && (size == 3'd1) && half_ok;
    else
      legal = base_ok;
  end
endmodule

// File: rtl/exp_rsp_ctrl.sv
module exp_rsp_ctrl
  import exp_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_seen,
  input  logic req_legal,
  input  logic cmd_ready,
  output logic hreadyout,
  output logic hresp,
  output logic cmd_valid,
  output logic capture_en
);
  rsp_state_e state_q, state_d;
  logic       open_phase;

  always_comb begin
    unique case (state_q)
      RS_OPEN:  hreadyout = 1'b1;
      RS_HOLD:  hreadyout = cmd_ready;
      RS_ERR_A: hreadyout = 1'b0;
      default:  hreadyout = 1'b1;
    endcase
    hresp      = (state_q == RS_ERR_A) || (state_q == RS_ERR_B);
    cmd_valid  = (state_q == RS_HOLD);
    open_phase = hreadyout && req_seen;
    capture_en = open_phase && req_legal;
  end

  always_comb begin
    state_d = state_q;
    if (open_phase)
      state_d = req_legal ? RS_HOLD : RS_ERR_A;
    else if (state_q == RS_ERR_A)
      state_d = RS_ERR_B;
    else if (hreadyout)
      state_d = RS_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_OPEN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/exp_cmd_filter.sv
module exp_cmd_filter
  import exp_cmd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LINE_WORDS = 8,
  localparam int BW = $clog2(LINE_WORDS) + 1,
  localparam int LW = $clog2(LINE_WORDS) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [1:0]    htrans,
  input  logic [2:0]    hburst,
  input  logic [2:0]    hsize,
  input  logic          hwrite,
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    cfg_width,
  input  logic [2:0]    cfg_kind,
  input  logic          cfg_byte_rd,
  output logic          hreadyout,
  output logic          hresp,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_write,
  output logic [1:0]    cmd_size,
  output logic          cmd_wrap,
  output logic [BW-1:0] cmd_beats,
  output logic [AW-1:0] cmd_addr
);
  logic          req_seen, req_legal, rule_wrap, capture_en;
  logic [BW-1:0] rule_beats;

  logic          write_q, write_d, wrap_q, wrap_d;
  logic [1:0]    size_q, size_d;
  logic [BW-1:0] beats_q, beats_d;
  logic [AW-1:0] addr_q, addr_d;

  assign req_seen = hsel && (htrans == TR_NSEQ);

  exp_cmd_rules #(.LINE_WORDS(LINE_WORDS)) u_rules (
    .burst  (hburst),
    .size   (hsize),
    .write  (hwrite),
    .addr_lo(haddr[LW-1:0]),
    .width  (cfg_width),
    .kind   (cfg_kind),
    .byte_rd(cfg_byte_rd),
    .legal  (req_legal),
    .wrap   (rule_wrap),
    .beats  (rule_beats)
  );

  exp_rsp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_seen  (req_seen),
    .req_legal (req_legal),
    .cmd_ready (cmd_ready),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .cmd_valid (cmd_valid),
    .capture_en(capture_en)
  );

  always_comb begin
    write_d = write_q;
    wrap_d  = wrap_q;
    size_d  = size_q;
    beats_d = beats_q;
    addr_d  = addr_q;
    if (capture_en) begin
      write_d = hwrite;
      wrap_d  = rule_wrap;
      size_d  = hsize[1:0];
      beats_d = rule_beats;
      addr_d  = haddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      wrap_q  <= 1'b0;
      size_q  <= '0;
      beats_q <= '0;
      addr_q  <= '0;
    end else begin
      write_q <= write_d;
      wrap_q  <= wrap_d;
      size_q  <= size_d;
      beats_q <= beats_d;
      addr_q  <= addr_d;
    end
  end

  assign cmd_write = write_q;
  assign cmd_wrap  = wrap_q;
  assign cmd_size  = size_q;
  assign cmd_beats = beats_q;
  assign cmd_addr  = addr_q;
endmodule

// File: rtl/exp_cmd_filter_chk.sv
module exp_cmd_filter_chk #(
  parameter int AW = 32,
  parameter int BW = 4,
  parameter int LINE_WORDS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hreadyout,
  input logic          hresp,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [BW-1:0] cmd_beats,
  input logic [AW-1:0] cmd_addr,
  input logic          cmd_write,
  input logic          cmd_wrap
);
  assert_err_second_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  assert_err_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && hreadyout) |-> $past(hresp && !hreadyout));

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_beats)
                                   && $stable(cmd_write) && $stable(cmd_wrap)));

  assert_ready_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (hreadyout == cmd_ready));

  assert_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !hresp) |-> hreadyout);

  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, hresp}));

  assert_beats_max_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_beats <= BW'(LINE_WORDS)));
endmodule

bind exp_cmd_filter exp_cmd_filter_chk #(.AW(AW), .BW(BW), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hreadyout(hreadyout), .hresp(hresp), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_beats(cmd_beats), .cmd_addr(cmd_addr), .cmd_write(cmd_write),
  .cmd_wrap(cmd_wrap)
);

// File: tb/test_exp_cmd_filter.sv
module test_exp_cmd_filter;
  localparam int AW = 32;
  localparam int BW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsel = 1'b0, hwrite = 1'b0, cfg_byte_rd = 1'b0, cmd_ready = 1'b1;
  logic [1:0] htrans = 2'b00, cfg_width = 2'd2;
  logic [2:0] hburst = 3'd0, hsize = 3'd2, cfg_kind = 3'd0;
  logic [AW-1:0] haddr = '0;
  logic hreadyout, hresp, cmd_valid, cmd_write, cmd_wrap;
  logic [1:0] cmd_size;
  logic [BW-1:0] cmd_beats;
  logic [AW-1:0] cmd_addr;

  int errors = 0, checks = 0;
  string tag = "R1";

  // behavioural model state: 0 open, 1 holding command, 2 error beat one, 3 error beat two
  int ms = 0;
  int m_beats = 0, m_size = 0;
  bit m_write = 0, m_wrap = 0;
  logic [AW-1:0] m_addr = '0;

  always #2.5 clk = ~clk;

  exp_cmd_filter #(.AW(AW)) i_exp_cmd_filter (
    .clk, .rst_n, .hsel, .htrans, .hburst, .hsize, .hwrite, .haddr, .cfg_width, .cfg_kind,
    .cfg_byte_rd, .hreadyout, .hresp, .cmd_valid, .cmd_ready, .cmd_write, .cmd_size,
    .cmd_wrap, .cmd_beats, .cmd_addr
  );

  // returns -1 when refused, else the beat count
  function automatic int model_beats(int b, int s, bit w, int a, int wd, int k, bit br);
    int lo = a % 32;
    if (wd == 3 || k > 4) return -1;                         // R13
    if (k == 3 || k == 4)                                    // R9
      return (b == 0 && s == 1 && lo % 2 == 0) ? 1 : -1;
    if (b == 0) begin                                        // R3 R4 R5
      if (s == 0) begin
        if (w) return (k == 1) ? -1 : 1;
        return (wd == 1 && !br) ? -1 : 1;
      end
      if (s == 1) return (lo % 2 != 0 || (w && k == 1 && wd == 1)) ? -1 : 1;
      if (s == 2) return (lo % 4 != 0) ? -1 : 1;
      return -1;
    end
    if (b == 3 || b == 5) begin                              // R6
      if (s != 2 || lo % 4 != 0 || lo > 16) return -1;
      if (w && !(k == 2 && wd == 2)) return -1;
      return (b == 3) ? 4 : 8;
    end
    if (b == 4) return (!w && s == 2 && lo == 0) ? 8 : -1;   // R7
    if (b == 1) begin                                        // R8
      if (s != 2 || lo % 4 != 0 || !(k == 2 && wd == 2)) return -1;
      return w ? 0 : 8 - lo / 4;
    end
    return -1;
  endfunction

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare outputs now, then advance one clock and step the model
  task automatic cycle();
    int e_rdy, r;
    #1;
    e_rdy = (ms == 0 || ms == 3) ? 1 : (ms == 1) ? int'(cmd_ready) : 0;
    cmp("hreadyout", int'(hreadyout), e_rdy);
    cmp("hresp", int'(hresp), (ms >= 2) ? 1 : 0);
    cmp("cmd_valid", int'(cmd_valid), (ms == 1) ? 1 : 0);
    if (ms == 1) begin
      cmp("cmd_beats", int'(cmd_beats), m_beats);
      cmp("cmd_write", int'(cmd_write), int'(m_write));
      cmp("cmd_wrap", int'(cmd_wrap), int'(m_wrap));
      cmp("cmd_size", int'(cmd_size), m_size);
      cmp("cmd_addr", int'(cmd_addr), int'(m_addr));
    end
    @(posedge clk);
    if (e_rdy == 1 && hsel && htrans == 2'b10) begin
      r = model_beats(int'(hburst), int'(hsize), hwrite, int'(haddr), int'(cfg_width),
                      int'(cfg_kind), cfg_byte_rd);
      if (r < 0) ms = 2;
      else begin
        ms = 1; m_beats = r; m_write = hwrite; m_wrap = (hburst == 3'd4);
        m_size = int'(hsize[1:0]); m_addr = haddr;
      end
    end else if (ms == 2) ms = 3;
    else if (e_rdy == 1) ms = 0;
    @(negedge clk);
  endtask

  task automatic set_cfg(int wd, int k, bit br);
    cfg_width = 2'(wd); cfg_kind = 3'(k); cfg_byte_rd = br;
  endtask

  // one request then idle until the reply finishes
  task automatic req(string t, int b, int s, bit w, int a);
    tag = t; hsel = 1; htrans = 2'b10; hburst = 3'(b); hsize = 3'(s); hwrite = w; haddr = AW'(a);
    cycle();
    htrans = 2'b00;
    cycle(); cycle();
  endtask

  initial begin
    @(negedge clk);
    tag = "R1"; #1;
    cmp("reset hreadyout", int'(hreadyout), 1);
    cmp("reset hresp", int'(hresp), 0);
    cmp("reset cmd_valid", int'(cmd_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    cycle();
    // R2: idle, busy, seq and deselected nonseq
    tag = "R2"; hsel = 1; htrans = 2'b00; cycle();
    htrans = 2'b01; cycle();
    htrans = 2'b11; hburst = 3'd3; cycle();
    hsel = 0; htrans = 2'b10; cycle();
    htrans = 2'b00;
    set_cfg(2, 0, 0);
    // R3
    req("R3", 0, 0, 0, 32'h103); req("R3", 0, 1, 0, 32'h102); req("R3", 0, 1, 1, 32'h101);
    req("R3", 0, 2, 0, 32'h104); req("R3", 0, 2, 1, 32'h106); req("R3", 0, 3, 0, 32'h100);
    // R4
    set_cfg(1, 0, 0); req("R4", 0, 0, 0, 32'h11);
    set_cfg(1, 0, 1); req("R4", 0, 0, 0, 32'h11);
    set_cfg(0, 0, 0); req("R4", 0, 0, 0, 32'h13);
    // R5
    set_cfg(2, 1, 1); req("R5", 0, 0, 1, 32'h20); req("R5", 0, 1, 1, 32'h22);
    req("R5", 0, 0, 0, 32'h21);
    set_cfg(1, 1, 1); req("R5", 0, 1, 1, 32'h22); req("R5", 0, 1, 0, 32'h22);
    // R6
    set_cfg(2, 0, 0); req("R6", 3, 2, 0, 32'h210); req("R6", 5, 2, 0, 32'h214);
    req("R6", 3, 1, 0, 32'h200); req("R6", 5, 2, 1, 32'h200);
    set_cfg(2, 2, 0); req("R6", 5, 2, 1, 32'h200); req("R6", 3, 2, 1, 32'h210);
    set_cfg(1, 2, 0); req("R6", 3, 2, 1, 32'h200);
    // R7
    set_cfg(2, 2, 0); req("R7", 4, 2, 0, 32'h300); req("R7", 4, 2, 0, 32'h304);
    req("R7", 4, 2, 1, 32'h300); req("R7", 2, 2, 0, 32'h300); req("R7", 6, 2, 0, 32'h300);
    req("R7", 7, 2, 1, 32'h300);
    // R8
    req("R8", 1, 2, 0, 32'h400); req("R8", 1, 2, 0, 32'h41C); req("R8", 1, 2, 0, 32'h40C);
    req("R8", 1, 2, 1, 32'h408); req("R8", 1, 1, 0, 32'h400);
    set_cfg(2, 0, 0); req("R8", 1, 2, 0, 32'h400);
    // R9
    set_cfg(1, 3, 1); req("R9", 0, 1, 0, 32'h502); req("R9", 0, 0, 0, 32'h500);
    set_cfg(1, 4, 0); req("R9", 0, 1, 1, 32'h504); req("R9", 0, 2, 0, 32'h500);
    req("R9", 3, 1, 0, 32'h500); req("R9", 0, 1, 0, 32'h501);
    // R13
    set_cfg(3, 0, 1); req("R13", 0, 2, 0, 32'h600);
    set_cfg(2, 6, 1); req("R13", 0, 2, 0, 32'h600);
    // R11: downstream stalls three cycles
    set_cfg(2, 2, 0);
    tag = "R11"; cmd_ready = 0; htrans = 2'b10; hburst = 3'd5; hsize = 3'd2; hwrite = 1;
    haddr = 32'h700; cycle();
    htrans = 2'b00; haddr = 32'hFFF; cycle(); cycle(); cycle();
    // R11 overlap: new request presented while cmd_ready rises
    tag = "R11"; cmd_ready = 1; htrans = 2'b10; hburst = 3'd1; hwrite = 0; haddr = 32'h718;
    cycle();
    htrans = 2'b00; cycle(); cycle();
    // R10 overlap: new request presented in the closing error beat
    tag = "R10"; htrans = 2'b10; hburst = 3'd7; cycle();
    htrans = 2'b00; cycle();
    htrans = 2'b10; hburst = 3'd0; hsize = 3'd1; hwrite = 1; haddr = 32'h722; cycle();
    htrans = 2'b00; cycle(); cycle();
    // R12: field spot checks on a wrap read
    req("R12", 4, 2, 0, 32'h12340);
    // back-to-back errors
    tag = "R10"; htrans = 2'b10; hburst = 3'd6; cycle(); cycle(); cycle(); cycle();
    htrans = 2'b00; cycle(); cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule